// File: doc/BRIEF.md
# Expansion Card Bus Slave Decoder

This block is the glue between a 32-bit asynchronous processor bus and an expansion card that carries two slaves. One is a byte-wide identification ROM. The other is the register file of a network controller. The block watches the top address byte for the card's window, which is 0xF9000000 to 0xF9FFFFFF. Inside that window it checks whether the upper page bits are all ones.

A read from the top page of the window is a ROM cycle. The block enables the ROM, gives the ROM the low eight address bits, and acknowledges the cycle itself on both size-acknowledge lines. Every other address in the window is a controller cycle. For those, the block asserts the controller's chip select. It feeds the controller's slave strobe from the processor's data strobe, so that a glitch on read/write while the address strobe is low never reaches the controller's latch. During controller cycles the controller answers the bus on its own, and the block keeps its acknowledge drivers turned off.

All selects, strobes and acknowledges leave through one register stage on the card clock. Synchronous active-high reset returns them all to idle.

Top module: `bus_slave_glue`

## Requirements
- R1: While reset is high, and in the first cycle after it, rom_sel_n, ctl_cs_n and ctl_strobe_n are 1, ack_n is 2'b11 and ack_oe is 0.
- R2: If a clock edge samples as_n=0, rw=1 (1 means read) and addr[31:24]=0xF9 with addr[23:8]=0xFFFF, then after that edge rom_sel_n=0, ack_n=2'b00 and ack_oe=1.
- R3: If a clock edge samples as_n=1, then after that edge rom_sel_n=1, ack_n=2'b11 and ack_oe=0.
- R4: rom_addr always equals addr[7:0], with no clock delay.
- R5: If a clock edge samples as_n=0 and addr[31:24]=0xF9 with addr[23:8] not all ones, then after that edge ctl_cs_n=0, and ack_oe stays 0 whatever the value of rw.
- R6: During a controller cycle (as in R5), ctl_strobe_n takes the value of ds_n sampled at the edge. In every other cycle it is 1, so it can fall only after ds_n has been seen low.
- R7: Changing rw while as_n is low does not change ctl_cs_n or ctl_strobe_n.
- R8: If addr[31:24] is not 0xF9, no select, strobe or acknowledge is asserted, whatever as_n, ds_n and rw are.
- R9: A write (rw=0) to the ROM page asserts neither rom_sel_n, nor ctl_cs_n, nor any acknowledge. The ROM and the controller are never selected together.
- R10: While as_n is high, ds_n has no effect: ctl_strobe_n and ctl_cs_n stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 32 | Processor address bus |
| as_n | input | 1 | Processor address strobe, active low |
| ds_n | input | 1 | Processor data strobe, active low |
| rw | input | 1 | Processor read/write, 1 = read |
| rom_addr | output | 8 | Byte offset given to the ROM |
| rom_sel_n | output | 1 | ROM enable, active low |
| ctl_cs_n | output | 1 | Controller chip select, active low |
| ctl_strobe_n | output | 1 | Controller slave address strobe, active low |
| ack_n | output | 2 | Size-acknowledge values driven by the glue, active low |
| ack_oe | output | 1 | Enable for the acknowledge drivers |

## Verification
Every registered output (the ROM enable, both acknowledges and their enable, the chip select and the controller strobe) is due exactly one clock edge after the inputs that cause it are sampled. Only rom_addr is combinational and due in the same cycle. The driver changes inputs on the falling edge and queues the outputs it expects after the next rising edge. The monitor pops and compares those values a short delay after that rising edge, and rom_addr is checked just after the inputs settle. The read/write glitch cases flip rw on successive falling edges while the strobes are held, so any response to rw would show up as a miscompare one edge later.

// File: rtl/glue_pkg.sv
package glue_pkg;

    typedef enum logic [1:0] {
        SPACE_NONE = 2'd0,
        SPACE_ROM  = 2'd1,
        SPACE_CTL  = 2'd2
    } space_e;

    typedef struct packed {
        logic       sel_n;
        logic [1:0] ack_n;
        logic       ack_oe;
    } rom_side_t;

    typedef struct packed {
        logic cs_n;
        logic strobe_n;
    } ctl_side_t;

    localparam rom_side_t ROM_IDLE = '{sel_n: 1'b1, ack_n: 2'b11, ack_oe: 1'b0};
    localparam ctl_side_t CTL_IDLE = '{cs_n: 1'b1, strobe_n: 1'b1};

    function automatic space_e classify(input logic in_window, input logic top_page);
        if (!in_window)
            return SPACE_NONE;
        else if (top_page)
            return SPACE_ROM;
        else
            return SPACE_CTL;
    endfunction

endpackage

// File: rtl/glue_addr_decode.sv
module glue_addr_decode
    import glue_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int TAG_W   = 8,
    parameter logic [TAG_W-1:0] WIN_TAG = 8'hF9,
    parameter int OFFS_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output space_e            space,
    output logic [OFFS_W-1:0] offset
);
    localparam int PAGE_LO = OFFS_W;
    localparam int PAGE_HI = ADDR_W - TAG_W - 1;

    logic in_window;
    logic top_page;

    always_comb begin
        in_window = (addr[ADDR_W-1 -: TAG_W] == WIN_TAG);
        top_page  = &addr[PAGE_HI:PAGE_LO];
        space     = classify(in_window, top_page);
        offset    = addr[OFFS_W-1:0];
    end
endmodule

// File: rtl/glue_rom_ack.sv
module glue_rom_ack
    import glue_pkg::*;
#(
    parameter int ACK_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             rw,
    input  space_e           space,
    output logic             sel_n,
    output logic [ACK_W-1:0] ack_n,
    output logic             ack_oe
);
    logic rom_cycle;
    logic sel_q;

    assign rom_cycle = !as_n && rw && (space == SPACE_ROM);

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= 1'b0;
        else
            sel_q <= rom_cycle;
    end

    assign sel_n  = !sel_q;
    assign ack_oe = sel_q;

    for (genvar i = 0; i < ACK_W; i++) begin : g_ack
        logic ack_q;
        always_ff @(posedge clk) begin
            if (rst)
                ack_q <= 1'b0;
            else
                ack_q <= rom_cycle;
        end
        assign ack_n[i] = !ack_q;
    end
endmodule

// File: rtl/glue_ctl_strobe.sv
module glue_ctl_strobe
    import glue_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      as_n,
    input  logic      ds_n,
    input  space_e    space,
    output ctl_side_t ctl
);
    logic      ctl_cycle;
    ctl_side_t nxt;

    always_comb begin
        ctl_cycle = !as_n && (space == SPACE_CTL);
        nxt       = CTL_IDLE;
        if (ctl_cycle) begin
            nxt.cs_n     = 1'b0;
            nxt.strobe_n = ds_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl <= CTL_IDLE;
        else
            ctl <= nxt;
    end
endmodule

// File: rtl/bus_slave_glue.sv
module bus_slave_glue
    import glue_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 8,
    parameter logic [TAG_W-1:0] WIN_TAG = 8'hF9,
    parameter int OFFS_W = 8,
    parameter int ACK_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_n,
    input  logic              ds_n,
    input  logic              rw,
    output logic [OFFS_W-1:0] rom_addr,
    output logic              rom_sel_n,
    output logic              ctl_cs_n,
    output logic              ctl_strobe_n,
    output logic [ACK_W-1:0]  ack_n,
    output logic              ack_oe
);
    space_e    space;
    ctl_side_t ctl;

    glue_addr_decode #(
        .ADDR_W (ADDR_W),
        .TAG_W  (TAG_W),
        .WIN_TAG(WIN_TAG),
        .OFFS_W (OFFS_W)
    ) u_decode (
        .addr  (addr),
        .space (space),
        .offset(rom_addr)
    );

    glue_rom_ack #(
        .ACK_W(ACK_W)
    ) u_rom (
        .clk   (clk),
        .rst   (rst),
        .as_n  (as_n),
        .rw    (rw),
        .space (space),
        .sel_n (rom_sel_n),
        .ack_n (ack_n),
        .ack_oe(ack_oe)
    );

    glue_ctl_strobe u_ctl (
        .clk  (clk),
        .rst  (rst),
        .as_n (as_n),
        .ds_n (ds_n),
        .space(space),
        .ctl  (ctl)
    );

    assign ctl_cs_n     = ctl.cs_n;
    assign ctl_strobe_n = ctl.strobe_n;
endmodule

// File: rtl/bus_slave_glue_chk.sv
module bus_slave_glue_chk #(
    parameter int ACK_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             as_n,
    input logic             ds_n,
    input logic             rom_sel_n,
    input logic             ctl_cs_n,
    input logic             ctl_strobe_n,
    input logic [ACK_W-1:0] ack_n,
    input logic             ack_oe
);
    assert_rom_ack_pair_R2: assert property (@(posedge clk) disable iff (rst)
        !rom_sel_n |-> (ack_n == '0) && ack_oe);

    assert_release_on_as_R3: assert property (@(posedge clk) disable iff (rst)
        as_n |=> rom_sel_n && (ack_n == '1) && !ack_oe);

    assert_no_ack_ctl_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl_cs_n |-> !ack_oe);

    assert_strobe_needs_cs_R6: assert property (@(posedge clk) disable iff (rst)
        !ctl_strobe_n |-> !ctl_cs_n);

    assert_strobe_falls_with_ds_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_strobe_n) |-> !$past(ds_n));

    assert_exclusive_select_R9: assert property (@(posedge clk) disable iff (rst)
        !(!rom_sel_n && !ctl_cs_n));

    assert_idle_without_as_R10: assert property (@(posedge clk) disable iff (rst)
        as_n |=> ctl_cs_n && ctl_strobe_n);
endmodule

bind bus_slave_glue bus_slave_glue_chk #(.ACK_W(ACK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .as_n        (as_n),
    .ds_n        (ds_n),
    .rom_sel_n   (rom_sel_n),
    .ctl_cs_n    (ctl_cs_n),
    .ctl_strobe_n(ctl_strobe_n),
    .ack_n       (ack_n),
    .ack_oe      (ack_oe)
);

// File: tb/test_bus_slave_glue.sv
module test_bus_slave_glue;

    typedef struct packed {
        logic       rom_sel_n;
        logic       cs_n;
        logic       strobe_n;
        logic [1:0] ack_n;
        logic       ack_oe;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr = 32'h0;
    logic        as_n = 1'b1;
    logic        ds_n = 1'b1;
    logic        rw   = 1'b1;
    logic [7:0]  rom_addr;
    logic        rom_sel_n, ctl_cs_n, ctl_strobe_n, ack_oe;
    logic [1:0]  ack_n;

    int vectors = 0;
    int errors  = 0;
    obs_t  exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    bus_slave_glue i_bus_slave_glue (
        .clk(clk), .rst(rst), .addr(addr), .as_n(as_n), .ds_n(ds_n), .rw(rw),
        .rom_addr(rom_addr), .rom_sel_n(rom_sel_n), .ctl_cs_n(ctl_cs_n),
        .ctl_strobe_n(ctl_strobe_n), .ack_n(ack_n), .ack_oe(ack_oe)
    );

    function automatic obs_t observed();
        return '{rom_sel_n: rom_sel_n, cs_n: ctl_cs_n, strobe_n: ctl_strobe_n,
                 ack_n: ack_n, ack_oe: ack_oe};
    endfunction

    function automatic obs_t model(input logic [31:0] a, input logic as, input logic ds,
                                   input logic r);
        obs_t o;
        logic win, page;
        win  = (a[31:24] == 8'hF9);
        page = (a[23:8] == 16'hFFFF);
        o = '{rom_sel_n: 1'b1, cs_n: 1'b1, strobe_n: 1'b1, ack_n: 2'b11, ack_oe: 1'b0};
        if (!as && win && page && r) begin
            o.rom_sel_n = 1'b0;
            o.ack_n     = 2'b00;
            o.ack_oe    = 1'b1;
        end
        if (!as && win && !page) begin
            o.cs_n     = 1'b0;
            o.strobe_n = ds;
        end
        return o;
    endfunction

    task automatic compare(input string tag, input obs_t act, input obs_t exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got sel=%b cs=%b stb=%b ack=%b oe=%b, want sel=%b cs=%b stb=%b ack=%b oe=%b",
                     tag, act.rom_sel_n, act.cs_n, act.strobe_n, act.ack_n, act.ack_oe,
                     exp.rom_sel_n, exp.cs_n, exp.strobe_n, exp.ack_n, exp.ack_oe);
        end
    endtask

    // Driver: apply inputs on the falling edge, queue the outputs due after the next rising edge.
    task automatic drive(input string tag, input logic [31:0] a, input logic as,
                         input logic ds, input logic r);
        @(negedge clk);
        addr = a; as_n = as; ds_n = ds; rw = r;
        exp_q.push_back(model(a, as, ds, r));
        tag_q.push_back(tag);
        #1;
        vectors++;
        if (rom_addr !== a[7:0]) begin
            errors++;
            $display("FAIL R4: rom_addr got %h want %h", rom_addr, a[7:0]);
        end
    endtask

    // Monitor: pop and compare shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(tag_q.pop_front(), observed(), exp_q.pop_front());
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got hung run want completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    localparam obs_t IDLE = '{rom_sel_n: 1'b1, cs_n: 1'b1, strobe_n: 1'b1,
                              ack_n: 2'b11, ack_oe: 1'b0};

    initial begin
        // R1: asserted reset with an active ROM read on the inputs
        addr = 32'hF9FF_FF10; as_n = 1'b0; rw = 1'b1; ds_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 compare("R1 reset", observed(), IDLE);
        @(negedge clk);
        addr = 32'h0; as_n = 1'b1; ds_n = 1'b1;
        rst = 1'b0;
        @(posedge clk);
        #1 compare("R1 after reset", observed(), IDLE);

        // R2/R3/R4: ROM read cycles at page offsets
        drive("R2 rom read start", 32'hF9FF_FF00, 1'b0, 1'b1, 1'b1);
        drive("R2 rom read ds", 32'hF9FF_FF00, 1'b0, 1'b0, 1'b1);
        drive("R3 rom release", 32'hF9FF_FF00, 1'b1, 1'b1, 1'b1);
        drive("R2 rom read top", 32'hF9FF_FFFF, 1'b0, 1'b0, 1'b1);
        drive("R4 rom offset", 32'hF9FF_FF5A, 1'b0, 1'b0, 1'b1);
        drive("R3 rom end", 32'hF9FF_FF5A, 1'b1, 1'b1, 1'b1);

        // R9: write to the ROM page
        drive("R9 rom write", 32'hF9FF_FF20, 1'b0, 1'b1, 1'b0);
        drive("R9 rom write ds", 32'hF9FF_FF20, 1'b0, 1'b0, 1'b0);
        drive("R3 idle", 32'hF9FF_FF20, 1'b1, 1'b1, 1'b0);

        // R5/R6: controller read and write cycles
        drive("R5 ctl read as", 32'hF900_0040, 1'b0, 1'b1, 1'b1);
        drive("R6 ctl read ds", 32'hF900_0040, 1'b0, 1'b0, 1'b1);
        drive("R6 ctl read hold", 32'hF900_0040, 1'b0, 1'b0, 1'b1);
        drive("R6 ctl end", 32'hF900_0040, 1'b1, 1'b1, 1'b1);
        drive("R5 ctl write as", 32'hF9FF_FE00, 1'b0, 1'b1, 1'b0);
        drive("R6 ctl write ds", 32'hF9FF_FE00, 1'b0, 1'b0, 1'b0);
        drive("R6 ctl write end", 32'hF9FF_FE00, 1'b1, 1'b1, 1'b0);

        // R7: read/write glitches with the address strobe low, before and during ds
        drive("R7 glitch pre-ds a", 32'hF912_3400, 1'b0, 1'b1, 1'b0);
        drive("R7 glitch pre-ds b", 32'hF912_3400, 1'b0, 1'b1, 1'b1);
        drive("R7 glitch pre-ds c", 32'hF912_3400, 1'b0, 1'b1, 1'b0);
        drive("R7 glitch ds a", 32'hF912_3400, 1'b0, 1'b0, 1'b1);
        drive("R7 glitch ds b", 32'hF912_3400, 1'b0, 1'b0, 1'b0);
        drive("R7 glitch ds c", 32'hF912_3400, 1'b0, 1'b0, 1'b1);
        drive("R7 glitch end", 32'hF912_3400, 1'b1, 1'b1, 1'b1);

        // R8: addresses outside the window
        drive("R8 below window", 32'hF8FF_FF00, 1'b0, 1'b0, 1'b1);
        drive("R8 above window", 32'hFAFF_FF00, 1'b0, 1'b0, 1'b1);
        drive("R8 low memory", 32'h0000_1000, 1'b0, 1'b0, 1'b0);
        drive("R8 end", 32'h0000_1000, 1'b1, 1'b1, 1'b1);

        // R10: data strobe alone with no address strobe
        drive("R10 ds only ctl", 32'hF900_0080, 1'b1, 1'b0, 1'b1);
        drive("R10 ds only rom", 32'hF9FF_FF80, 1'b1, 1'b0, 1'b1);

        // back-to-back ROM then controller
        drive("R2 rom back2back", 32'hF9FF_FF04, 1'b0, 1'b0, 1'b1);
        drive("R5 ctl back2back", 32'hF900_0004, 1'b0, 1'b0, 1'b1);
        drive("R3 final idle", 32'hF900_0004, 1'b1, 1'b1, 1'b1);

        @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule